// File: doc/BRIEF.md
# Serial Register Access Engine

This block is a serial master that gives a host single-cycle command access to an external peripheral whose registers are 24 bits wide. The host presents one command at a time on a request/acknowledge port: a read, a write, a masked write, or a batch read or batch write over a short list of register addresses. The engine checks the command, turns it into one or more 32-bit frames and shifts them over a four-wire serial link: clock, chip select, master-out and master-in. When the last frame has finished it reports the result.

A masked write is a read-modify-write of one register. The engine first reads the register in one frame. It then merges the host data into the bits selected by the mask and writes the result back in the frame that follows at once. The host sees the value the register held before the update. Set-bits and clear-bits are masked writes with the data equal to the mask or equal to zero. A command is checked in full before any frame goes out, so a bad address, a bad operation code or a bad list length never reaches the link.

Top module: `regspi_engine`

## Requirements
- R1: Every frame is 32 bits, sent MSB first. Bit 31 is 1 for a write and 0 for a read. Bits 30:25 carry the register address, bit 24 is 0, and bits 23:0 carry the write data, or zero in a read frame.
- R2: Chip select goes low for exactly one frame, which is 32 rising clock edges. It goes high between frames. The serial clock idles low and the master samples master-in on the rising edge (mode 0).
- R3: A read (op 0) sends one read frame. `rsp_data` then holds bits 23:0 of the word shifted in during that frame, and `done_cnt` is 1.
- R4: A write (op 1) sends one write frame carrying bits 23:0 of `req_data`. Bits 31:24 of `req_data` and `req_mask` are ignored by every command.
- R5: A masked write (op 2) sends a read frame and then, with no other frame between, a write frame to the same address. The write data is (data AND mask) OR (old AND NOT mask). `rsp_data` returns the old value and `done_cnt` is 2.
- R6: A command with op 0, 1 or 2 whose address is at or above `NUM_REGS` is rejected, and so is any op code from 5 to 7. A rejected command is acknowledged, sends no frame, and completes with `err`=1 and `done_cnt`=0.
- R7: A batch read (op 3) sends `req_len` read frames to the list entries 0, 1, ... in order. For each frame it pulses `item_valid` with the entry index and its 24-bit readback. `done_cnt` equals `req_len`.
- R8: A batch write (op 4) sends `req_len` write frames in list order. Entry i carries address `req_list_addr[6i+:6]` and data `req_list_data[32i+:24]`.
- R9: A batch is rejected as a whole, with no frame sent, if any of its first `req_len` entries is out of range or if `req_len` is 0 or greater than `MAX_BATCH`. Entries at index `req_len` or higher are not checked.
- R10: `req_ack` pulses only for a request seen while idle. `busy` is high from the acknowledge cycle of an accepted command to its `done` cycle. A request made while busy gets no acknowledge and sends no frame.
- R11: `err` is high only together with `done`. It is set exactly when `done_cnt` is less than the number of frames the command asked for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request |
| req_op | input | 3 | Operation: 0 read, 1 write, 2 masked write, 3 batch read, 4 batch write |
| req_addr | input | 6 | Register address for single commands |
| req_data | input | 32 | Write data (low 24 bits used) |
| req_mask | input | 32 | Masked-write mask (low 24 bits used) |
| req_len | input | CNT_W | Batch entry count, where CNT_W = clog2(max(MAX_BATCH,2)+1) |
| req_list_addr | input | 6*MAX_BATCH | Batch address list, entry i at [6i+:6] |
| req_list_data | input | 32*MAX_BATCH | Batch write data, entry i at [32i+:32] |
| req_ack | output | 1 | Request taken (one cycle) |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one cycle) |
| done_cnt | output | CNT_W | Frames completed by the command |
| err | output | 1 | Command rejected, valid with done |
| rsp_data | output | 24 | Read value or old value of a masked write |
| item_valid | output | 1 | Batch read entry ready |
| item_idx | output | IDX_W | Batch entry index, IDX_W = clog2(MAX_BATCH) |
| item_data | output | 24 | Batch read entry value |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Master-out data |
| spi_miso | input | 1 | Master-in data |

## Verification
A wrong frame index or a stale list pointer shows up at the link as soon as chip select rises: the address or data field of the frame just sent names the wrong register, or the batch frames arrive in the wrong order. A bad copy of the old value in a masked write is seen one frame later, in the write-back data and in `rsp_data`. A sequencer stuck in a wrong state shows either as `busy` never falling or as a frame count that differs from `done_cnt` when `done` is raised. A validation fault is seen on the first bad command, because it then puts a frame on the link where none is allowed.

// File: rtl/regspi_pkg.sv
package regspi_pkg;

    localparam int FRAME_W = 32;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 24;
    localparam int HOST_W  = 32;

    typedef enum logic [2:0] {
        OP_RD  = 3'd0,
        OP_WR  = 3'd1,
        OP_RMW = 3'd2,
        OP_BRD = 3'd3,
        OP_BWR = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_SHIFT,
        SH_GAP
    } sh_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } sq_state_e;

    // direction | address | pad | payload
    function automatic logic [FRAME_W-1:0] build_frame(input logic wr,
                                                       input logic [ADDR_W-1:0] a,
                                                       input logic [DATA_W-1:0] d);
        return {wr, a, 1'b0, d};
    endfunction

    function automatic logic [DATA_W-1:0] merge_bits(input logic [DATA_W-1:0] d,
                                                     input logic [DATA_W-1:0] m,
                                                     input logic [DATA_W-1:0] old);
        return (d & m) | (old & ~m);
    endfunction

    function automatic logic [DATA_W-1:0] low_data(input logic [HOST_W-1:0] v);
        return v[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/regspi_admit.sv
module regspi_admit
    import regspi_pkg::*;
#(
    parameter int NUM_REGS  = 48,
    parameter int MAX_BATCH = 4,
    parameter int CNT_W     = 3
) (
    input  logic [2:0]                  op,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [CNT_W-1:0]            len,
    input  logic [MAX_BATCH*ADDR_W-1:0] list_addr,
    output logic                        ok,
    output logic [CNT_W-1:0]            frames
);
    localparam logic [ADDR_W:0]  ADDR_LIM = (ADDR_W+1)'(NUM_REGS);
    localparam logic [CNT_W-1:0] LEN_MAX  = CNT_W'(MAX_BATCH);

    logic [MAX_BATCH-1:0] entry_ok;
    logic                 single_ok;

    assign single_ok = {1'b0, addr} < ADDR_LIM;

    for (genvar i = 0; i < MAX_BATCH; i++) begin : g_entry
        logic [ADDR_W-1:0] ea;
        assign ea          = list_addr[i*ADDR_W +: ADDR_W];
        assign entry_ok[i] = (CNT_W'(i) >= len) || ({1'b0, ea} < ADDR_LIM);
    end

    always_comb begin
        ok     = 1'b0;
        frames = '0;
        case (op)
            OP_RD, OP_WR: begin
                ok     = single_ok;
                frames = CNT_W'(1);
            end
            OP_RMW: begin
                ok     = single_ok;
                frames = CNT_W'(2);
            end
            OP_BRD, OP_BWR: begin
                ok     = (len != '0) && (len <= LEN_MAX) && (&entry_ok);
                frames = len;
            end
            default: begin
                ok     = 1'b0;
                frames = '0;
            end
        endcase
    end
endmodule

// File: rtl/regspi_shifter.sv
module regspi_shifter
    import regspi_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_frame,
    output logic               done,
    output logic [FRAME_W-1:0] rx_frame,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    input  logic               miso
);
    localparam int               DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
    localparam int               BIT_W    = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

    sh_state_e          st;
    logic [DIV_W-1:0]   div;
    logic [BIT_W-1:0]   nbit;
    logic [FRAME_W-1:0] tx_sh;
    logic [FRAME_W-1:0] rx_sh;
    logic               tick;

    assign tick     = (div == DIV_LAST);
    assign mosi     = tx_sh[FRAME_W-1];
    assign rx_frame = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SH_IDLE;
            div   <= '0;
            nbit  <= '0;
            tx_sh <= '0;
            rx_sh <= '0;
            sclk  <= 1'b0;
            cs_n  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SH_IDLE: begin
                    div <= '0;
                    if (start) begin
                        tx_sh <= tx_frame;
                        nbit  <= '0;
                        cs_n  <= 1'b0;
                        st    <= SH_SHIFT;
                    end
                end
                SH_SHIFT: begin
                    div <= tick ? '0 : div + 1'b1;
                    if (tick) begin
                        if (!sclk) begin
                            sclk  <= 1'b1;
                            rx_sh <= {rx_sh[FRAME_W-2:0], miso};
                        end else begin
                            sclk <= 1'b0;
                            if (nbit == BIT_LAST) begin
                                cs_n <= 1'b1;
                                st   <= SH_GAP;
                            end else begin
                                nbit  <= nbit + 1'b1;
                                tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
                            end
                        end
                    end
                end
                SH_GAP: begin
                    div <= tick ? '0 : div + 1'b1;
                    if (tick) begin
                        st   <= SH_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regspi_seq.sv
module regspi_seq
    import regspi_pkg::*;
#(
    parameter int MAX_BATCH = 4,
    parameter int CNT_W     = 3,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [2:0]                  req_op,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [HOST_W-1:0]           req_data,
    input  logic [HOST_W-1:0]           req_mask,
    input  logic [MAX_BATCH*ADDR_W-1:0] req_list_addr,
    input  logic [MAX_BATCH*HOST_W-1:0] req_list_data,
    input  logic                        adm_ok,
    input  logic [CNT_W-1:0]            adm_frames,
    output logic                        req_ack,
    output logic                        busy,
    output logic                        done,
    output logic [CNT_W-1:0]            done_cnt,
    output logic                        err,
    output logic [DATA_W-1:0]           rsp_data,
    output logic                        item_valid,
    output logic [IDX_W-1:0]            item_idx,
    output logic [DATA_W-1:0]           item_data,
    output logic                        sh_start,
    output logic [FRAME_W-1:0]          sh_frame,
    input  logic                        sh_done,
    input  logic [FRAME_W-1:0]          sh_rx
);
    sq_state_e          st;
    op_e                op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic [DATA_W-1:0]  mask_q;
    logic [DATA_W-1:0]  old_q;
    logic [ADDR_W-1:0]  lst_a [MAX_BATCH];
    logic [DATA_W-1:0]  lst_d [MAX_BATCH];
    logic [CNT_W-1:0]   total;
    logic [CNT_W-1:0]   idx;
    logic [IDX_W-1:0]   sel;
    logic [FRAME_W-1:0] cur_frame;
    logic [DATA_W-1:0]  rx_data;

    assign sel     = idx[IDX_W-1:0];
    assign rx_data = low_data(sh_rx);

    always_comb begin
        case (op_q)
            OP_RD:   cur_frame = build_frame(1'b0, addr_q, '0);
            OP_WR:   cur_frame = build_frame(1'b1, addr_q, data_q);
            OP_RMW:  cur_frame = (idx == '0) ? build_frame(1'b0, addr_q, '0)
                                             : build_frame(1'b1, addr_q,
                                                           merge_bits(data_q, mask_q, old_q));
            OP_BRD:  cur_frame = build_frame(1'b0, lst_a[sel], '0);
            OP_BWR:  cur_frame = build_frame(1'b1, lst_a[sel], lst_d[sel]);
            default: cur_frame = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            op_q       <= OP_RD;
            addr_q     <= '0;
            data_q     <= '0;
            mask_q     <= '0;
            old_q      <= '0;
            total      <= '0;
            idx        <= '0;
            req_ack    <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b0;
            done_cnt   <= '0;
            err        <= 1'b0;
            rsp_data   <= '0;
            item_valid <= 1'b0;
            item_idx   <= '0;
            item_data  <= '0;
            sh_start   <= 1'b0;
            sh_frame   <= '0;
            for (int i = 0; i < MAX_BATCH; i++) begin
                lst_a[i] <= '0;
                lst_d[i] <= '0;
            end
        end else begin
            req_ack    <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
            item_valid <= 1'b0;
            sh_start   <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (req_valid) begin
                        req_ack  <= 1'b1;
                        rsp_data <= '0;
                        if (adm_ok) begin
                            op_q   <= op_e'(req_op);
                            addr_q <= req_addr;
                            data_q <= low_data(req_data);
                            mask_q <= low_data(req_mask);
                            for (int i = 0; i < MAX_BATCH; i++) begin
                                lst_a[i] <= req_list_addr[i*ADDR_W +: ADDR_W];
                                lst_d[i] <= low_data(req_list_data[i*HOST_W +: HOST_W]);
                            end
                            total <= adm_frames;
                            idx   <= '0;
                            busy  <= 1'b1;
                            st    <= SQ_ISSUE;
                        end else begin
                            done     <= 1'b1;
                            err      <= 1'b1;
                            done_cnt <= '0;
                        end
                    end
                end
                SQ_ISSUE: begin
                    sh_start <= 1'b1;
                    sh_frame <= cur_frame;
                    st       <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (sh_done) begin
                        if (!sh_frame[FRAME_W-1]) begin
                            rsp_data <= rx_data;
                            old_q    <= rx_data;
                            if (op_q == OP_BRD) begin
                                item_valid <= 1'b1;
                                item_idx   <= sel;
                                item_data  <= rx_data;
                            end
                        end
                        if ((idx + 1'b1) == total) begin
                            done     <= 1'b1;
                            busy     <= 1'b0;
                            done_cnt <= idx + 1'b1;
                            st       <= SQ_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= SQ_ISSUE;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regspi_engine.sv
module regspi_engine
    import regspi_pkg::*;
#(
    parameter int NUM_REGS  = 48,
    parameter int MAX_BATCH = 4,
    parameter int CLK_DIV   = 2,
    localparam int CNT_W    = $clog2(((MAX_BATCH > 2) ? MAX_BATCH : 2) + 1),
    localparam int IDX_W    = (MAX_BATCH > 1) ? $clog2(MAX_BATCH) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [2:0]                  req_op,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [HOST_W-1:0]           req_data,
    input  logic [HOST_W-1:0]           req_mask,
    input  logic [CNT_W-1:0]            req_len,
    input  logic [MAX_BATCH*ADDR_W-1:0] req_list_addr,
    input  logic [MAX_BATCH*HOST_W-1:0] req_list_data,
    output logic                        req_ack,
    output logic                        busy,
    output logic                        done,
    output logic [CNT_W-1:0]            done_cnt,
    output logic                        err,
    output logic [DATA_W-1:0]           rsp_data,
    output logic                        item_valid,
    output logic [IDX_W-1:0]            item_idx,
    output logic [DATA_W-1:0]           item_data,
    output logic                        spi_sclk,
    output logic                        spi_cs_n,
    output logic                        spi_mosi,
    input  logic                        spi_miso
);
    logic               adm_ok;
    logic [CNT_W-1:0]   adm_frames;
    logic               sh_start;
    logic [FRAME_W-1:0] sh_frame;
    logic               sh_done;
    logic [FRAME_W-1:0] sh_rx;

    regspi_admit #(
        .NUM_REGS (NUM_REGS),
        .MAX_BATCH(MAX_BATCH),
        .CNT_W    (CNT_W)
    ) u_admit (
        .op       (req_op),
        .addr     (req_addr),
        .len      (req_len),
        .list_addr(req_list_addr),
        .ok       (adm_ok),
        .frames   (adm_frames)
    );

    regspi_seq #(
        .MAX_BATCH(MAX_BATCH),
        .CNT_W    (CNT_W),
        .IDX_W    (IDX_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_op       (req_op),
        .req_addr     (req_addr),
        .req_data     (req_data),
        .req_mask     (req_mask),
        .req_list_addr(req_list_addr),
        .req_list_data(req_list_data),
        .adm_ok       (adm_ok),
        .adm_frames   (adm_frames),
        .req_ack      (req_ack),
        .busy         (busy),
        .done         (done),
        .done_cnt     (done_cnt),
        .err          (err),
        .rsp_data     (rsp_data),
        .item_valid   (item_valid),
        .item_idx     (item_idx),
        .item_data    (item_data),
        .sh_start     (sh_start),
        .sh_frame     (sh_frame),
        .sh_done      (sh_done),
        .sh_rx        (sh_rx)
    );

    regspi_shifter #(
        .CLK_DIV(CLK_DIV)
    ) u_phy (
        .clk     (clk),
        .rst     (rst),
        .start   (sh_start),
        .tx_frame(sh_frame),
        .done    (sh_done),
        .rx_frame(sh_rx),
        .sclk    (spi_sclk),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );
endmodule

// File: rtl/regspi_checker.sv
module regspi_checker (
    input logic clk,
    input logic rst,
    input logic req_ack,
    input logic busy,
    input logic done,
    input logic err,
    input logic spi_sclk,
    input logic spi_cs_n
);
    logic       sclk_q;
    logic [5:0] rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            rises  <= '0;
        end else begin
            sclk_q <= spi_sclk;
            if (spi_cs_n)
                rises <= '0;
            else if (spi_sclk && !sclk_q)
                rises <= rises + 1'b1;
        end
    end

    AST_FRAME_EDGES: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> (rises == 6'd32));                         // R2
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);                                       // R2
    AST_FRAME_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> busy);                                           // R10
    AST_ACK_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> !$past(busy));                                     // R10
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> done);                                                 // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                               // R11
endmodule

bind regspi_engine regspi_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_ack (req_ack),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n)
);

// File: tb/regspi_engine_bench.sv
module regspi_engine_bench;
    import regspi_pkg::*;

    localparam int NREG = 48;
    localparam int MAXB = 4;
    localparam int DIV  = 2;
    localparam int CW   = 3;
    localparam int IW   = 2;

    logic            clk, rst;
    logic            req_valid;
    logic [2:0]      req_op;
    logic [5:0]      req_addr;
    logic [31:0]     req_data, req_mask;
    logic [CW-1:0]   req_len;
    logic [MAXB*6-1:0]  req_list_addr;
    logic [MAXB*32-1:0] req_list_data;
    logic            req_ack, busy, done, err;
    logic [CW-1:0]   done_cnt;
    logic [23:0]     rsp_data, item_data;
    logic            item_valid;
    logic [IW-1:0]   item_idx;
    logic            spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    regspi_engine #(.NUM_REGS(NREG), .MAX_BATCH(MAXB), .CLK_DIV(DIV)) u_regspi_engine (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .req_mask(req_mask), .req_len(req_len),
        .req_list_addr(req_list_addr), .req_list_data(req_list_data),
        .req_ack(req_ack), .busy(busy), .done(done), .done_cnt(done_cnt), .err(err),
        .rsp_data(rsp_data), .item_valid(item_valid), .item_idx(item_idx),
        .item_data(item_data), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;

    // ---------------- peripheral model ----------------
    int          bit_n = 0;
    logic [31:0] sh_in = '0;
    logic [5:0]  s_addr = '0;
    logic [23:0] sregs [0:63];
    logic [31:0] flog  [0:511];
    int          fcount = 0;
    int          flen_bad = 0;

    initial spi_miso = 1'b0;

    always @(negedge spi_cs_n) begin
        bit_n    = 0;
        spi_miso = 1'b0;
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        sh_in = {sh_in[30:0], spi_mosi};
        bit_n++;
        if (bit_n == 7) s_addr = sh_in[5:0];
    end

    always @(negedge spi_sclk) if (!spi_cs_n) begin
        int pos;
        pos = 31 - bit_n;
        spi_miso = (pos >= 0 && pos <= 23) ? sregs[s_addr][pos] : 1'b0;
    end

    always @(posedge spi_cs_n) if (!rst) begin
        if (fcount < 512) flog[fcount] = sh_in;
        fcount++;
        if (bit_n != 32) flen_bad++;
        if (sh_in[31]) sregs[sh_in[30:25]] = sh_in[23:0];
    end

    // ---------------- output monitors ----------------
    int          ack_cnt = 0;
    int          err_orphan = 0;
    int          it_cnt = 0;
    logic [23:0] it_data [0:MAXB-1];
    logic [IW-1:0] it_idx [0:MAXB-1];

    always @(negedge clk) begin
        if (req_ack) ack_cnt++;
        if (err && !done) err_orphan++;
        if (item_valid) begin
            if (it_cnt < MAXB) begin
                it_data[it_cnt] = item_data;
                it_idx[it_cnt]  = item_idx;
            end
            it_cnt++;
        end
    end

    logic [23:0] mexp [0:63];
    logic [23:0] r_data;
    logic [CW-1:0] r_cnt;
    logic        r_err;

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [5:0] a,
                         input logic [31:0] d, input logic [31:0] m, input logic [CW-1:0] len);
        @(negedge clk);
        req_op    = op;
        req_addr  = a;
        req_data  = d;
        req_mask  = m;
        req_len   = len;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_cmd();
        while (!done) @(negedge clk);
        r_data = rsp_data;
        r_cnt  = done_cnt;
        r_err  = err;
        @(negedge clk);
    endtask

    function automatic logic [31:0] wv(input int a);
        return 32'hC300_0000 | ((32'(a) * 32'h0004_2F1B + 32'h0012_3456) & 32'h00FF_FFFF);
    endfunction

    function automatic logic [31:0] rframe(input int a);
        return {1'b0, 6'(a), 25'h0};
    endfunction

    function automatic logic [31:0] wframe(input int a, input logic [23:0] d);
        return {1'b1, 6'(a), 1'b0, d};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R10 watchdog: actual busy=%0b expected command completion", busy);
        report();
    end

    initial begin
        int f0;
        int a0;
        logic [31:0] w;
        for (int i = 0; i < 64; i++) begin
            sregs[i] = 24'(i * 24'h000313 ^ 24'h800001);
            mexp[i]  = sregs[i];
        end
        rst = 1'b1;
        req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0; req_mask = '0;
        req_len = '0; req_list_addr = '0; req_list_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R10 reset busy", {31'b0, busy}, 0);
        chk("R11 reset done", {31'b0, done}, 0);
        chk("R2 reset cs_n", {31'b0, spi_cs_n}, 1);
        chk("R2 reset sclk", {31'b0, spi_sclk}, 0);

        // R4 / R1: write every register, upper host bits set
        for (int a = 0; a < NREG; a++) begin
            f0 = fcount;
            w  = wv(a);
            issue(OP_WR, 6'(a), w, 32'hFFFF_FFFF, '0);
            finish_cmd();
            mexp[a] = w[23:0];
            chk("R4 write frame count", fcount - f0, 1);
            chk("R1 R4 write frame", flog[f0], wframe(a, w[23:0]));
            chk("R4 write done_cnt", {29'b0, r_cnt}, 1);
            chk("R11 write err", {31'b0, r_err}, 0);
        end

        // R3 / R1: read every register
        for (int a = 0; a < NREG; a++) begin
            f0 = fcount;
            issue(OP_RD, 6'(a), 32'hFFFF_FFFF, 32'h0, '0);
            chk("R10 busy after accept", {31'b0, busy}, 1);
            finish_cmd();
            chk("R10 busy cleared at done", {31'b0, busy}, 0);
            chk("R1 read frame", flog[f0], rframe(a));
            chk("R3 read data", {8'b0, r_data}, {8'b0, mexp[a]});
            chk("R3 read done_cnt", {29'b0, r_cnt}, 1);
        end

        // R6: out-of-range addresses and illegal op codes
        for (int a = NREG; a < 64; a++) begin
            for (int op = 0; op < 3; op++) begin
                f0 = fcount;
                a0 = ack_cnt;
                issue(3'(op), 6'(a), 32'h00AB_CDEF, 32'h00FF_FFFF, '0);
                chk("R6 reject no busy", {31'b0, busy}, 0);
                finish_cmd();
                chk("R6 reject err", {31'b0, r_err}, 1);
                chk("R6 reject done_cnt", {29'b0, r_cnt}, 0);
                chk("R6 reject no frame", fcount - f0, 0);
                chk("R10 reject acked", ack_cnt - a0, 1);
            end
        end
        for (int op = 5; op < 8; op++) begin
            f0 = fcount;
            issue(3'(op), 6'd3, 32'h1, 32'h1, 3'd2);
            finish_cmd();
            chk("R6 bad op err", {31'b0, r_err}, 1);
            chk("R6 bad op no frame", fcount - f0, 0);
        end

        // R5: masked writes, including set-bits and clear-bits forms
        for (int k = 0; k < 4; k++) begin
            int a;
            a = (k == 0) ? 0 : (k == 1) ? 9 : (k == 2) ? 30 : 47;
            for (int p = 0; p < 4; p++) begin
                logic [31:0] d, m;
                logic [23:0] old, nw;
                case (p)
                    0: begin d = 32'hFF12_3456; m = 32'hFF00_FFFF; end
                    1: begin d = 32'h0000_0000; m = 32'h00FF_0000; end
                    2: begin d = 32'h0F0F_0F0F; m = 32'h0F0F_0F0F; end
                    default: begin d = 32'h00FF_FFFF; m = 32'h0000_0000; end
                endcase
                old = mexp[a];
                nw  = (d[23:0] & m[23:0]) | (old & ~m[23:0]);
                f0  = fcount;
                issue(OP_RMW, 6'(a), d, m, '0);
                finish_cmd();
                mexp[a] = nw;
                chk("R5 old value returned", {8'b0, r_data}, {8'b0, old});
                chk("R5 done_cnt", {29'b0, r_cnt}, 2);
                chk("R5 frame count", fcount - f0, 2);
                chk("R5 first frame reads", flog[f0], rframe(a));
                chk("R5 R4 second frame merges", flog[f0 + 1], wframe(a, nw));
            end
            issue(OP_RD, 6'(a), '0, '0, '0);
            finish_cmd();
            chk("R5 register after merges", {8'b0, r_data}, {8'b0, mexp[a]});
        end

        // R7: batch reads of each length
        for (int len = 1; len <= MAXB; len++) begin
            int la [0:MAXB-1];
            for (int i = 0; i < MAXB; i++) begin
                la[i] = (len * 11 + i * 17) % NREG;
                req_list_addr[i*6 +: 6] = 6'(la[i]);
            end
            f0 = fcount;
            it_cnt = 0;
            issue(OP_BRD, 6'd0, '0, '0, CW'(len));
            finish_cmd();
            chk("R7 batch done_cnt", {29'b0, r_cnt}, 32'(len));
            chk("R7 batch item count", it_cnt, len);
            chk("R7 batch frame count", fcount - f0, len);
            for (int i = 0; i < len; i++) begin
                chk("R7 batch frame order", flog[f0 + i], rframe(la[i]));
                chk("R7 batch item data", {8'b0, it_data[i]}, {8'b0, mexp[la[i]]});
                chk("R7 batch item index", {30'b0, it_idx[i]}, 32'(i));
            end
        end

        // R8: batch write with a repeated address, later entry wins
        begin
            int la [0:MAXB-1];
            logic [31:0] ld [0:MAXB-1];
            la[0] = 44; la[1] = 2; la[2] = 44; la[3] = 17;
            for (int i = 0; i < MAXB; i++) begin
                ld[i] = 32'hAB00_0000 | (32'(i) * 32'h0011_1111 + 32'h000F_0E0D);
                req_list_addr[i*6 +: 6]   = 6'(la[i]);
                req_list_data[i*32 +: 32] = ld[i];
            end
            f0 = fcount;
            issue(OP_BWR, 6'd0, '0, '0, CW'(MAXB));
            finish_cmd();
            chk("R8 batch write done_cnt", {29'b0, r_cnt}, MAXB);
            for (int i = 0; i < MAXB; i++) begin
                chk("R8 batch write frame", flog[f0 + i], wframe(la[i], ld[i][23:0]));
                mexp[la[i]] = ld[i][23:0];
            end
            la[0] = 44; la[1] = 2; la[2] = 17; la[3] = 0;
            for (int i = 0; i < MAXB; i++) req_list_addr[i*6 +: 6] = 6'(la[i]);
            it_cnt = 0;
            issue(OP_BRD, 6'd0, '0, '0, CW'(MAXB));
            finish_cmd();
            for (int i = 0; i < MAXB; i++)
                chk("R8 batch write readback", {8'b0, it_data[i]}, {8'b0, mexp[la[i]]});
        end

        // R9: batch rejection rules
        for (int k = 0; k < MAXB; k++) begin
            for (int i = 0; i < MAXB; i++) req_list_addr[i*6 +: 6] = 6'(i + 5);
            req_list_addr[k*6 +: 6] = 6'(NREG + k * 5);
            f0 = fcount;
            issue((k % 2 == 0) ? OP_BRD : OP_BWR, 6'd0, '0, '0, CW'(MAXB));
            finish_cmd();
            chk("R9 bad entry rejects batch", {31'b0, r_err}, 1);
            chk("R9 bad entry no frame", fcount - f0, 0);
        end
        for (int i = 0; i < MAXB; i++) req_list_addr[i*6 +: 6] = 6'(i + 5);
        req_list_addr[3*6 +: 6] = 6'd60;
        f0 = fcount;
        issue(OP_BRD, 6'd0, '0, '0, 3'd3);
        finish_cmd();
        chk("R9 unused entry not checked err", {31'b0, r_err}, 0);
        chk("R9 unused entry frames", fcount - f0, 3);
        for (int len = 0; len < 8; len += 5) begin
            req_list_addr[3*6 +: 6] = 6'd8;
            f0 = fcount;
            issue(OP_BRD, 6'd0, '0, '0, CW'(len));
            finish_cmd();
            chk("R9 bad length err", {31'b0, r_err}, 1);
            chk("R9 bad length no frame", fcount - f0, 0);
            chk("R11 bad length done_cnt", {29'b0, r_cnt}, 0);
        end

        // R10: request during busy is ignored
        f0 = fcount;
        a0 = ack_cnt;
        issue(OP_RD, 6'd10, '0, '0, '0);
        repeat (20) @(negedge clk);
        chk("R10 busy mid frame", {31'b0, busy}, 1);
        req_op = OP_WR; req_addr = 6'd10; req_data = 32'h0055_AA55; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        finish_cmd();
        chk("R10 single ack while busy", ack_cnt - a0, 1);
        chk("R10 single frame while busy", fcount - f0, 1);
        chk("R3 read under busy request", {8'b0, r_data}, {8'b0, mexp[10]});
        issue(OP_RD, 6'd10, '0, '0, '0);
        finish_cmd();
        chk("R10 ignored write left register", {8'b0, r_data}, {8'b0, mexp[10]});

        chk("R2 frame length", flen_bad, 0);
        chk("R11 err without done", err_orphan, 0);
        report();
    end
endmodule